// File: doc/BRIEF.md
# SMBus host register interface

This block is the software-facing front end of an SMBus host controller. Software uses two ports. It writes an index through the first one, then reads or writes the selected internal byte through the second. The internal bytes are:

- a two-byte status word;
- a two-byte control word;
- the slave address with its direction bit;
- a command byte, a block pointer and a byte count;
- an eight-byte data window;
- a few spare bytes.

A write to the low control byte may carry a start request or a kill request. A start request is offered to the attached device in the same cycle on a simple transaction port. The block samples the device's address acknowledge and any returned bytes in that cycle. It then holds a host-busy status for as long as the same transfer would occupy the wire. After that it posts a final status code.

The busy time is counted in units of 60 µs, derived from the clock frequency parameter. Each byte on the wire costs nine units, and one extra unit covers start and stop. The address counts as a byte.

A level interrupt follows the result bits of the status word, gated by an enable input.

Top module: `smbus_host_regs`

## Requirements
- R1: A write with `reg_sel_i`=0 stores the index, and a read with `reg_sel_i`=0 returns it. Data-port reads and writes address the byte selected by the index: 0x04 address, 0x05 command, 0x07 count, 0x08..0x0F data window bytes 0..7, 0x10..0x12 spare bytes. Read data appears on `rdata_o` one cycle after the read strobe.
- R2: A write to index 0x13 stores the value with bit 0 forced to 0. Index 0xFF reads as 0x00 whatever was written to it.
- R3: A data write of index 0x02 with bit 4 set and bit 5 clear is a start. In that cycle `bus_go_o` is high, `bus_addr_o` equals address bits 7:1 and `bus_rnw_o` equals address bit 0. While the result is pending, the status word reads 0x0008.
- R4: The protocol is taken from written control bits 3:1. Code 0 (quick) counts 1 byte, code 1 (byte) 2 bytes, code 2 (byte-data) 3 bytes and code 3 (word-data) 4 bytes. For these codes, an acknowledged start posts status 0x40 exactly (1 + 9·bytes)·U cycles after the start edge, where U = (CLK_HZ/1000)·60/1000.
- R5: An acknowledged read start captures `bus_rdata_i[7:0]` into window byte 0 for codes 1, 2 and 3. For code 3 it also captures `bus_rdata_i[15:8]` into window byte 1. A write start leaves the window unchanged.
- R6: A start whose address is not acknowledged posts status 0x20 after 10·U cycles, whatever the protocol code.
- R7: An acknowledged start with protocol code 5 or any code above 3 posts status 0x10 after 1·U cycles.
- R8: A data write of index 0x02 with bit 5 set is a kill and takes priority over bit 4. If a result is pending, the status becomes 0x80 at once and the pending result is never posted. If nothing is pending, the status is unchanged and no start occurs.
- R9: A data write of index 0x00 clears the status bits among 7:4 that are set in the written value. A write of index 0x01 clears status bits 10:8 set in written bits 2:0. No other status bit is changed by these writes.
- R10: `irq_o` is high exactly when `irq_en_i` is high and any of status bits 7:4 is set. It drops in the same cycle that `irq_en_i` falls.
- R11: After reset the status is 0x0000, the block pointer reads 0x01, `irq_o` is low and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | 0 selects the index port, 1 the data port |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Level interrupt |
| bus_go_o | output | 1 | Transaction offered to the device this cycle |
| bus_addr_o | output | 7 | Slave address |
| bus_rnw_o | output | 1 | 1 = read transfer |
| bus_ack_i | input | 1 | Device acknowledged its address (sampled with bus_go_o) |
| bus_rdata_i | input | 16 | Bytes returned by the device (sampled with bus_go_o) |

## Verification
The bench builds the block with CLK_HZ = 100000, so one 60 µs unit is 6 cycles. The longest transfer, a word-data read of 37 units, then ends after 222 cycles. This lets every protocol code, the address-not-acknowledged path and the one-unit protocol-error path run to completion. Each completion edge is checked to the exact cycle. The short unit also leaves time to kill a transfer partway through and then wait well past its original end, to confirm the cancelled result never appears.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

    localparam int unsigned UNITS_W = 6;

    localparam logic [7:0] IX_STLO  = 8'h00;
    localparam logic [7:0] IX_STHI  = 8'h01;
    localparam logic [7:0] IX_CTLLO = 8'h02;
    localparam logic [7:0] IX_CTLHI = 8'h03;
    localparam logic [7:0] IX_ADDR  = 8'h04;
    localparam logic [7:0] IX_CMD   = 8'h05;
    localparam logic [7:0] IX_BLK   = 8'h06;
    localparam logic [7:0] IX_CNT   = 8'h07;
    localparam logic [7:0] IX_AUX0  = 8'h10;
    localparam logic [7:0] IX_AUX1  = 8'h11;
    localparam logic [7:0] IX_AUX2  = 8'h12;
    localparam logic [7:0] IX_ALIAS = 8'h13;
    localparam logic [7:0] IX_RSVD  = 8'hFF;

    localparam logic [7:0] ST_BUSY   = 8'h08;
    localparam logic [7:0] ST_PERR   = 8'h10;
    localparam logic [7:0] ST_NAK    = 8'h20;
    localparam logic [7:0] ST_DONE   = 8'h40;
    localparam logic [7:0] ST_KILLED = 8'h80;

    localparam logic [2:0] PR_QUICK = 3'd0;
    localparam logic [2:0] PR_BYTE  = 3'd1;
    localparam logic [2:0] PR_BDATA = 3'd2;
    localparam logic [2:0] PR_WORD  = 3'd3;

    typedef struct packed {
        logic [7:0]       idx;
        logic [15:0]      stat;
        logic [15:0]      ctl;
        logic [7:0]       addr;
        logic [7:0]       cmd;
        logic [7:0]       blk;
        logic [7:0]       cnt;
        logic [7:0][7:0]  win;
        logic [7:0]       aux0;
        logic [7:0]       aux1;
        logic [7:0]       aux2;
        logic [7:0]       alias8;
        logic [7:0]       res;
        logic [7:0]       rdata;
    } regs_t;

    function automatic logic [UNITS_W-1:0] wire_units(input logic [2:0] nbytes);
        return UNITS_W'(1) + UNITS_W'(9) * UNITS_W'(nbytes);
    endfunction

endpackage

// File: rtl/smbh_unit_tick.sv
module smbh_unit_tick #(
    parameter int unsigned UNIT_CYC = 6000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW = (UNIT_CYC < 2) ? 1 : $clog2(UNIT_CYC);
    localparam logic [CW-1:0] TOP = CW'(UNIT_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = TOP;
        end else if (run_i) begin
            cnt_d = (cnt_q == '0) ? TOP : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= TOP;
        else         cnt_q <= cnt_d;
    end

    // R4: the prescaler never leaves its 0..UNIT_CYC-1 range
    p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= TOP);

endmodule

// File: rtl/smbh_busy_timer.sv
module smbh_busy_timer
    import smbh_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic [UNITS_W-1:0] units_i,
    input  logic               cancel_i,
    input  logic               tick_i,
    output logic               pend_o,
    output logic               done_o
);
    logic               pend_d, pend_q;
    logic [UNITS_W-1:0] units_d, units_q;

    assign pend_o = pend_q;
    assign done_o = pend_q && tick_i && (units_q == UNITS_W'(1)) && !load_i && !cancel_i;

    always_comb begin
        pend_d  = pend_q;
        units_d = units_q;
        if (load_i) begin
            pend_d  = 1'b1;
            units_d = units_i;
        end else if (cancel_i) begin
            pend_d  = 1'b0;
            units_d = '0;
        end else if (pend_q && tick_i) begin
            units_d = units_q - 1'b1;
            if (units_q == UNITS_W'(1)) pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q  <= 1'b0;
            units_q <= '0;
        end else begin
            pend_q  <= pend_d;
            units_q <= units_d;
        end
    end

    // R4: a pending transfer always has units left to run
    p_units_nz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_q |-> (units_q != '0));

endmodule

// File: rtl/smbh_proto_dec.sv
module smbh_proto_dec
    import smbh_pkg::*;
(
    input  logic [2:0] proto_i,
    input  logic       ack_i,
    input  logic       rnw_i,
    output logic [2:0] nbytes_o,
    output logic [7:0] stat_o,
    output logic       cap0_o,
    output logic       cap1_o
);
    always_comb begin
        nbytes_o = 3'd1;
        stat_o   = ST_DONE;
        cap0_o   = 1'b0;
        cap1_o   = 1'b0;
        if (!ack_i) begin
            stat_o = ST_NAK;
        end else begin
            case (proto_i)
                PR_QUICK: nbytes_o = 3'd1;
                PR_BYTE: begin
                    nbytes_o = 3'd2;
                    cap0_o   = rnw_i;
                end
                PR_BDATA: begin
                    nbytes_o = 3'd3;
                    cap0_o   = rnw_i;
                end
                PR_WORD: begin
                    nbytes_o = 3'd4;
                    cap0_o   = rnw_i;
                    cap1_o   = rnw_i;
                end
                default: begin
                    nbytes_o = 3'd0;
                    stat_o   = ST_PERR;
                end
            endcase
        end
    end
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
    import smbh_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned UNIT_US = 60
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        reg_sel_i,
    input  logic        wr_en_i,
    input  logic        rd_en_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    input  logic        irq_en_i,
    output logic        irq_o,
    output logic        bus_go_o,
    output logic [6:0]  bus_addr_o,
    output logic        bus_rnw_o,
    input  logic        bus_ack_i,
    input  logic [15:0] bus_rdata_i
);
    localparam int unsigned UNIT_RAW = (CLK_HZ / 1000) * UNIT_US / 1000;
    localparam int unsigned UNIT_CYC = (UNIT_RAW < 1) ? 1 : UNIT_RAW;

    regs_t d, q;

    logic               idx_wr, dat_wr, kill_req, start_req;
    logic               tick, pend, tmr_done;
    logic [2:0]         dec_nbytes;
    logic [7:0]         dec_stat;
    logic               dec_cap0, dec_cap1;
    logic [UNITS_W-1:0] tmr_units;
    logic [7:0]         rd_mux;

    assign idx_wr    = wr_en_i && !reg_sel_i;
    assign dat_wr    = wr_en_i && reg_sel_i;
    assign kill_req  = dat_wr && (q.idx == IX_CTLLO) && wdata_i[5];
    assign start_req = dat_wr && (q.idx == IX_CTLLO) && !wdata_i[5] && wdata_i[4];
    assign tmr_units = wire_units(dec_nbytes);

    smbh_proto_dec u_dec (
        .proto_i  (wdata_i[3:1]),
        .ack_i    (bus_ack_i),
        .rnw_i    (q.addr[0]),
        .nbytes_o (dec_nbytes),
        .stat_o   (dec_stat),
        .cap0_o   (dec_cap0),
        .cap1_o   (dec_cap1)
    );

    smbh_unit_tick #(.UNIT_CYC(UNIT_CYC)) u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (start_req),
        .run_i     (pend),
        .tick_o    (tick)
    );

    smbh_busy_timer u_tmr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (start_req),
        .units_i  (tmr_units),
        .cancel_i (kill_req && pend),
        .tick_i   (tick),
        .pend_o   (pend),
        .done_o   (tmr_done)
    );

    always_comb begin
        rd_mux = 8'h00;
        case (q.idx)
            IX_STLO:  rd_mux = q.stat[7:0];
            IX_STHI:  rd_mux = q.stat[15:8];
            IX_CTLLO: rd_mux = q.ctl[7:0];
            IX_CTLHI: rd_mux = q.ctl[15:8];
            IX_ADDR:  rd_mux = q.addr;
            IX_CMD:   rd_mux = q.cmd;
            IX_BLK:   rd_mux = q.blk;
            IX_CNT:   rd_mux = q.cnt;
            IX_AUX0:  rd_mux = q.aux0;
            IX_AUX1:  rd_mux = q.aux1;
            IX_AUX2:  rd_mux = q.aux2;
            IX_ALIAS: rd_mux = q.alias8;
            IX_RSVD:  rd_mux = 8'h00;
            default: begin
                if (q.idx[7:3] == 5'd1) rd_mux = q.win[q.idx[2:0]];
            end
        endcase
    end

    always_comb begin
        d = q;
        if (tmr_done) d.stat = {8'h00, q.res};
        if (idx_wr) d.idx = wdata_i;
        if (dat_wr) begin
            case (q.idx)
                IX_STLO: begin
                    d.stat[7:4] = d.stat[7:4] & ~wdata_i[7:4];
                    if (d.stat == 16'h0004) d.stat = '0;
                end
                IX_STHI:  d.stat[10:8] = d.stat[10:8] & ~wdata_i[2:0];
                IX_CTLLO: begin
                    d.ctl[7:0] = wdata_i;
                    if (kill_req) begin
                        if (pend) d.stat = {8'h00, ST_KILLED};
                    end else if (start_req) begin
                        d.stat = {8'h00, ST_BUSY};
                        d.res  = dec_stat;
                        if (dec_cap0)  d.win[0] = bus_rdata_i[7:0];
                        if (dec_cap1)  d.win[1] = bus_rdata_i[15:8];
                        if (bus_ack_i) d.blk    = 8'd1;
                    end
                end
                IX_CTLHI: d.ctl[15:8] = wdata_i;
                IX_ADDR:  d.addr      = wdata_i;
                IX_CMD:   d.cmd       = wdata_i;
                IX_CNT:   d.cnt       = wdata_i;
                IX_AUX0:  d.aux0      = wdata_i;
                IX_AUX1:  d.aux1      = wdata_i;
                IX_AUX2:  d.aux2      = wdata_i;
                IX_ALIAS: d.alias8    = {wdata_i[7:1], 1'b0};
                default: begin
                    if (q.idx[7:3] == 5'd1) d.win[q.idx[2:0]] = wdata_i;
                end
            endcase
        end
        if (rd_en_i) d.rdata = reg_sel_i ? rd_mux : q.idx;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q     <= '0;
            q.blk <= 8'd1;
        end else begin
            q <= d;
        end
    end

    assign rdata_o    = q.rdata;
    assign irq_o      = irq_en_i && (|q.stat[7:4]);
    assign bus_go_o   = start_req;
    assign bus_addr_o = q.addr[7:1];
    assign bus_rnw_o  = q.addr[0];

    // R3: the status word shows host busy for the whole pending window
    p_busy_status_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend |-> (q.stat == 16'h0008));

    // R3: every transaction offered to the device starts the busy timer
    p_go_loads_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_go_o |=> pend);

    // R8: a kill of a pending transfer fails it and stops the timer
    p_kill_fail_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kill_req && pend) |=> (q.stat == 16'h0080 && !pend));

    // R10: no interrupt while interrupts are disabled
    p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_en_i |-> !irq_o);

endmodule

// File: tb/test_smbus_host_regs.sv
`timescale 1ns/1ps
module test_smbus_host_regs;
    localparam int unsigned U = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_en = 1'b0, irq;
    logic        go, rnw, ack = 1'b1;
    logic [6:0]  baddr;
    logic [15:0] brdata = '0;

    int nvec = 0, nbad = 0;
    int cyc = 0, go_cnt = 0;
    logic [6:0] go_addr = '0;
    logic       go_rnw = 1'b0;
    logic       rd_seen = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    smbus_host_regs #(.CLK_HZ(100_000), .UNIT_US(60)) i_smbus_host_regs (
        .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(reg_sel), .wr_en_i(wr_en),
        .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .irq_en_i(irq_en),
        .irq_o(irq), .bus_go_o(go), .bus_addr_o(baddr), .bus_rnw_o(rnw),
        .bus_ack_i(ack), .bus_rdata_i(brdata)
    );

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rd_seen <= rd_en;
        if (go) begin
            go_cnt  <= go_cnt + 1;
            go_addr <= baddr;
            go_rnw  <= rnw;
        end
    end

    // monitor: compares each read result against the scoreboard
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [7:0] e;
            string t;
            nvec++;
            if (exp_q.size() == 0) begin
                nbad++;
                $display("FAIL scoreboard empty act=%h exp=none", rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    nbad++;
                    $display("FAIL %s act=%h exp=%h", t, rdata, e);
                end
            end
        end
    end

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] v);
        reg_sel = sel; wr_en = 1'b1; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        reg_sel = sel; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] ix, input logic [7:0] v);
        wr(1'b0, ix);
        wr(1'b1, v);
    endtask

    task automatic reg_rd(input logic [7:0] ix, input logic [7:0] e, input string tag);
        wr(1'b0, ix);
        rd(1'b1, e, tag);
    endtask

    task automatic run_xfer(input logic [7:0] ctl, input int units,
                            input logic [7:0] exp_stat, input string tag);
        int g0, t0, lim;
        wr(1'b0, 8'h02);
        g0 = go_cnt;
        wr(1'b1, ctl);
        t0 = cyc;
        chk(16'(go_cnt - g0), 16'd1, {tag, " R3 go pulse"});
        wr(1'b0, 8'h00);
        rd(1'b1, 8'h08, {tag, " R3 busy status"});
        lim = 0;
        while (!irq && lim < 1000) begin
            @(negedge clk);
            lim++;
        end
        chk(16'(cyc - t0), 16'(units * U), {tag, " completion cycle"});
        rd(1'b1, exp_stat, {tag, " final status"});
    endtask

    initial begin
        #1_500_000;
        nbad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        int g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk({15'd0, irq}, 16'd0, "R11 irq after reset");
        reg_rd(8'h00, 8'h00, "R11 status low after reset");
        reg_rd(8'h06, 8'h01, "R11 block pointer after reset");

        // R1 index and plain registers
        wr(1'b0, 8'h05);
        rd(1'b0, 8'h05, "R1 index readback");
        reg_wr(8'h05, 8'hA5);
        reg_rd(8'h05, 8'hA5, "R1 command");
        reg_wr(8'h07, 8'h3C);
        reg_rd(8'h07, 8'h3C, "R1 count");
        for (int i = 0; i < 8; i++) reg_wr(8'(8 + i), 8'(8'h61 + 8'(i * 7)));
        for (int i = 0; i < 8; i++) reg_rd(8'(8 + i), 8'(8'h61 + 8'(i * 7)), "R1 data window");
        reg_wr(8'h10, 8'h11); reg_wr(8'h11, 8'h22); reg_wr(8'h12, 8'h33);
        reg_rd(8'h10, 8'h11, "R1 spare 0");
        reg_rd(8'h11, 8'h22, "R1 spare 1");
        reg_rd(8'h12, 8'h33, "R1 spare 2");

        // R2 masked bytes
        reg_wr(8'h13, 8'hFF);
        reg_rd(8'h13, 8'hFE, "R2 bit0 forced low");
        reg_wr(8'hFF, 8'hFF);
        reg_rd(8'hFF, 8'h00, "R2 reserved reads zero");

        irq_en = 1'b1;

        // R4 R5 byte read: 2 bytes -> 19 units
        reg_wr(8'h04, 8'h51);
        brdata = 16'hBEEF; ack = 1'b1;
        run_xfer(8'h12, 19, 8'h40, "R4 byte read");
        chk({9'd0, go_addr}, 16'h0028, "R3 address on bus");
        chk({15'd0, go_rnw}, 16'd1, "R3 direction on bus");
        reg_rd(8'h08, 8'hEF, "R5 byte read captured");
        reg_rd(8'h09, 8'h68, "R5 byte read leaves byte1");

        // R9 partial clears, then R10 enable drop
        reg_wr(8'h00, 8'h8F);
        rd(1'b1, 8'h40, "R9 unmasked bits kept");
        reg_wr(8'h01, 8'h07);
        rd(1'b1, 8'h00, "R9 high byte");
        reg_rd(8'h00, 8'h40, "R9 high-byte clear leaves low");
        irq_en = 1'b0;
        #1;
        chk({15'd0, irq}, 16'd0, "R10 irq drops with enable");
        irq_en = 1'b1;
        #1;
        chk({15'd0, irq}, 16'd1, "R10 irq with enable");
        @(negedge clk);
        reg_wr(8'h00, 8'h40);
        rd(1'b1, 8'h00, "R9 clear done bit");
        chk({15'd0, irq}, 16'd0, "R10 irq low after clear");

        // R4 R5 word read: 4 bytes -> 37 units
        brdata = 16'h1234;
        run_xfer(8'h16, 37, 8'h40, "R4 word read");
        reg_rd(8'h08, 8'h34, "R5 word low byte");
        reg_rd(8'h09, 8'h12, "R5 word high byte");

        // R4 R5 byte-data write: 3 bytes -> 28 units, no capture
        reg_wr(8'h04, 8'h50);
        brdata = 16'hAAAA;
        run_xfer(8'h14, 28, 8'h40, "R4 byte-data write");
        chk({15'd0, go_rnw}, 16'd0, "R3 write direction");
        reg_rd(8'h08, 8'h34, "R5 write leaves window");

        // R4 quick: 1 byte -> 10 units
        run_xfer(8'h10, 10, 8'h40, "R4 quick");

        // R6 not acknowledged
        ack = 1'b0;
        run_xfer(8'h16, 10, 8'h20, "R6 address nak");
        ack = 1'b1;

        // R7 block and unknown codes
        run_xfer(8'h1A, 1, 8'h10, "R7 block code");
        run_xfer(8'h1E, 1, 8'h10, "R7 code 7");

        // R8 kill of pending transfer
        wr(1'b0, 8'h02);
        wr(1'b1, 8'h14);
        wr(1'b1, 8'h20);
        reg_rd(8'h00, 8'h80, "R8 kill posts failed");
        chk({15'd0, irq}, 16'd1, "R10 irq on failed");
        repeat (200) @(negedge clk);
        rd(1'b1, 8'h80, "R8 cancelled result never posted");
        reg_wr(8'h00, 8'h80);
        rd(1'b1, 8'h00, "R9 clear failed bit");

        // R8 kill with start while idle
        g = go_cnt;
        reg_wr(8'h02, 8'h30);
        repeat (20) @(negedge clk);
        chk(16'(go_cnt - g), 16'd0, "R8 kill beats start");
        reg_rd(8'h00, 8'h00, "R8 idle kill leaves status");
        reg_rd(8'h02, 8'h30, "R1 control low stored");

        repeat (3) @(negedge clk);
        chk(16'(exp_q.size()), 16'd0, "R1 scoreboard drained");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule